// File: doc/BRIEF.md
# Color Channel Sampling Sequencer

This block decides which of three color channels (red, green, blue) a sampling front end takes next. It keeps a 9-bit configuration word and drives a registered one-hot select. A bit in the word sets the direction of travel. Three enable bits pick the channels that one- and two-channel operation visit. A separate mode input chooses between one-, two- and three-channel operation.

A per-sample advance strobe steps the select along the active sequence and wraps from the last channel to the first. A line-start resync pulse puts the sequence back on its first channel. Configuration writes are held in a staging register. They reach the sequencer only at the next resync, so a write in the middle of a line leaves the running order untouched. An error flag reports a staged word that is illegal for the current mode. While the flag is up, the select stays where it is.

Top module: `chan_seq`

## Requirements
- R1: While `rst_n` is low, `sel` is 3'b100 (red) and `cfg_err` is 0. The staged and active words both become 9'h0C0: forward order, red only.
- R2: `sel` is a registered one-hot vector at all times after reset, with bit 2 = red, bit 1 = green and bit 0 = blue.
- R3: With `mode` = 2'b10 or 2'b11 (three-channel) and bit 7 of the active word at 1, each accepted `adv` moves `sel` red → green → blue → red.
- R4: With three-channel mode and bit 7 of the active word at 0, each accepted `adv` moves `sel` blue → green → red → blue.
- R5: On `line_sync`, `sel` goes to the first channel of the sequence: red for forward order, blue for reverse in three-channel mode. `line_sync` wins over an `adv` in the same cycle.
- R6: With `mode` = 2'b01 (two-channel), the enabled channels are word bits 6 (red), 5 (green) and 4 (blue). `adv` alternates between the two enabled channels. `line_sync` selects the enabled channel that comes first in the programmed direction.
- R7: With `mode` = 2'b00 (one-channel), `sel` stays on its channel and `adv` has no effect. `line_sync` selects the single enabled channel.
- R8: A word written with `cfg_we` is staged. Order and enables change only at the next `line_sync` that is accepted.
- R9: `cfg_err` rises one cycle after the staged word has a 1 in a reserved bit (bit 8 or bits 3..0).
- R10: `cfg_err` is high one cycle after the staged word's enable count differs from the mode: not 1 in one-channel mode, or not 2 in two-channel mode.
- R11: While `cfg_err` is high, `sel` does not change. Both `adv` and `line_sync` are ignored, and the staged word is not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | Configuration word to stage |
| mode | input | 2 | 00 one-channel, 01 two-channel, 1x three-channel |
| line_sync | input | 1 | Line-start resync pulse |
| adv | input | 1 | Per-sample advance strobe |
| sel | output | 3 | One-hot channel select (2 red, 1 green, 0 blue) |
| cfg_err | output | 1 | Staged configuration illegal for the mode |

## Verification
The bench uses the default parameters: three channels, a 9-bit word, the order bit at 7, the enables at 6..4 and a reset word of 9'h0C0. With these values every color pair is reachable in both directions. Every wrap point of the three-channel rotation can be reached, and both the reserved-bit and the count-mismatch error paths can be triggered. The vector walk checks the staging delay by writing a reversed word mid-line. It also holds the sequencer in error across advance and resync strobes, then clears the error and confirms the old active word still governs stepping.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
    typedef enum logic [1:0] {
        MODE_ONE    = 2'b00,
        MODE_TWO    = 2'b01,
        MODE_THREE  = 2'b10,
        MODE_THREE2 = 2'b11
    } seq_mode_e;
endpackage

// File: rtl/chan_seq_cfg_check.sv
module chan_seq_cfg_check #(
    parameter int CFG_W     = 9,
    parameter int ORDER_BIT = 7,
    parameter int EN_LSB    = 4,
    parameter int NCH       = 3
) (
    input  logic [CFG_W-1:0] word,
    input  logic [1:0]       mode,
    output logic             bad
);
    import chan_seq_pkg::*;

    localparam int CW = $clog2(NCH + 1);
    localparam logic [CFG_W-1:0] USED_MASK =
        (CFG_W'(1) << ORDER_BIT) | (CFG_W'((1 << NCH) - 1) << EN_LSB);

    logic [NCH-1:0] en;
    logic [CW-1:0]  cnt;

    always_comb begin
        en  = word[EN_LSB +: NCH];
        cnt = '0;
        for (int i = 0; i < NCH; i++) begin
            cnt = cnt + CW'(en[i]);
        end
        bad = |(word & ~USED_MASK);
        case (seq_mode_e'(mode))
            MODE_ONE: bad = bad | (cnt != CW'(1));
            MODE_TWO: bad = bad | (cnt != CW'(2));
            default:  bad = bad;
        endcase
    end
endmodule

// File: rtl/chan_seq_first.sv
module chan_seq_first #(
    parameter int NCH = 3
) (
    input  logic [NCH-1:0] en,
    input  logic           fwd,
    input  logic [NCH-1:0] fallback,
    output logic [NCH-1:0] first
);
    // Forward order starts at the highest enabled bit, reverse at the lowest.
    always_comb begin
        first = fallback;
        if (fwd) begin
            for (int i = 0; i < NCH; i++) begin
                if (en[i]) begin
                    first    = '0;
                    first[i] = 1'b1;
                end
            end
        end else begin
            for (int i = NCH - 1; i >= 0; i--) begin
                if (en[i]) begin
                    first    = '0;
                    first[i] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/chan_seq_advance.sv
module chan_seq_advance #(
    parameter int NCH = 3
) (
    input  logic [NCH-1:0] sel,
    input  logic [NCH-1:0] en,
    input  logic           fwd,
    output logic [NCH-1:0] nxt
);
    logic [NCH-1:0] cand;
    logic           found;

    // Walk the ring in the programmed direction until an enabled channel is hit.
    always_comb begin
        nxt   = sel;
        cand  = sel;
        found = 1'b0;
        for (int k = 1; k < NCH; k++) begin
            cand = fwd ? {cand[0], cand[NCH-1:1]} : {cand[NCH-2:0], cand[NCH-1]};
            if (!found && |(cand & en)) begin
                nxt   = cand;
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/chan_seq.sv
module chan_seq #(
    parameter int CFG_W     = 9,
    parameter int ORDER_BIT = 7,
    parameter int EN_LSB    = 4,
    parameter int NCH       = 3,
    parameter logic [CFG_W-1:0] RST_WORD = 9'h0C0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [1:0]       mode,
    input  logic             line_sync,
    input  logic             adv,
    output logic [NCH-1:0]   sel,
    output logic             cfg_err
);
    import chan_seq_pkg::*;

    function automatic logic [NCH-1:0] pick_first(logic [NCH-1:0] en, logic fwd);
        logic [NCH-1:0] r;
        r = '0;
        for (int i = 0; i < NCH; i++) begin
            if (fwd && en[i]) begin
                r    = '0;
                r[i] = 1'b1;
            end
        end
        for (int i = NCH - 1; i >= 0; i--) begin
            if (!fwd && en[i]) begin
                r    = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

    localparam logic [NCH-1:0] RST_EN  = RST_WORD[EN_LSB +: NCH];
    localparam logic           RST_FWD = RST_WORD[ORDER_BIT];
    localparam logic [NCH-1:0] RST_SEL = pick_first(RST_EN, RST_FWD);

    typedef struct packed {
        logic [CFG_W-1:0] pend;
        logic             act_fwd;
        logic [NCH-1:0]   act_en;
        logic [NCH-1:0]   sel;
        logic             err;
    } seq_state_t;

    seq_state_t     state_d, state_q;
    logic [CFG_W-1:0] pend_nxt;
    logic           pend_bad;
    logic           three_mode;
    logic [NCH-1:0] load_en, run_en;
    logic [NCH-1:0] load_sel, step_sel;

    always_comb begin
        three_mode = mode[1];
        pend_nxt   = cfg_we ? cfg_wdata : state_q.pend;
        load_en    = three_mode ? '1 : state_q.pend[EN_LSB +: NCH];
        run_en     = three_mode ? '1 : state_q.act_en;
    end

    chan_seq_cfg_check #(
        .CFG_W(CFG_W), .ORDER_BIT(ORDER_BIT), .EN_LSB(EN_LSB), .NCH(NCH)
    ) u_check (
        .word (pend_nxt),
        .mode (mode),
        .bad  (pend_bad)
    );

    chan_seq_first #(.NCH(NCH)) u_first (
        .en       (load_en),
        .fwd      (state_q.pend[ORDER_BIT]),
        .fallback (state_q.sel),
        .first    (load_sel)
    );

    chan_seq_advance #(.NCH(NCH)) u_adv (
        .sel (state_q.sel),
        .en  (run_en),
        .fwd (state_q.act_fwd),
        .nxt (step_sel)
    );

    always_comb begin
        state_d      = state_q;
        state_d.pend = pend_nxt;
        state_d.err  = pend_bad;
        if (!state_q.err) begin
            if (line_sync) begin
                state_d.act_fwd = state_q.pend[ORDER_BIT];
                state_d.act_en  = state_q.pend[EN_LSB +: NCH];
                state_d.sel     = load_sel;
            end else if (adv && (seq_mode_e'(mode) != MODE_ONE)) begin
                state_d.sel = step_sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.pend    <= RST_WORD;
            state_q.act_fwd <= RST_FWD;
            state_q.act_en  <= RST_EN;
            state_q.sel     <= RST_SEL;
            state_q.err     <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sel     = state_q.sel;
    assign cfg_err = state_q.err;
endmodule

// File: rtl/chan_seq_sva.sv
module chan_seq_sva #(
    parameter int CFG_W     = 9,
    parameter int ORDER_BIT = 7,
    parameter int EN_LSB    = 4,
    parameter int NCH       = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [1:0]       mode,
    input logic             line_sync,
    input logic             adv,
    input logic [NCH-1:0]   sel,
    input logic             cfg_err
);
    localparam logic [CFG_W-1:0] RSV_MASK =
        ~((CFG_W'(1) << ORDER_BIT) | (CFG_W'((1 << NCH) - 1) << EN_LSB));

    // R2
    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) == 1);

    // R11
    a_r11_err_freezes_sel: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> $stable(sel));

    // R7
    a_r7_single_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !line_sync) |=> $stable(sel));

    // R9
    a_r9_reserved_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && |(cfg_wdata & RSV_MASK)) |=> cfg_err);

    // R3 and R4: a three-channel step always lands on another channel
    a_r3_three_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && adv && !line_sync && !cfg_err) |=> (sel != $past(sel)));
endmodule

bind chan_seq chan_seq_sva #(
    .CFG_W(CFG_W), .ORDER_BIT(ORDER_BIT), .EN_LSB(EN_LSB), .NCH(NCH)
) u_sva (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mode(mode), .line_sync(line_sync), .adv(adv), .sel(sel), .cfg_err(cfg_err)
);

// File: tb/chan_seq_bench.sv
module chan_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [8:0] cfg_wdata;
    logic [1:0] mode;
    logic       line_sync;
    logic       adv;
    logic [2:0] sel;
    logic       cfg_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    chan_seq u_chan_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .mode(mode), .line_sync(line_sync), .adv(adv), .sel(sel), .cfg_err(cfg_err)
    );

    // {req, we, wdata, mode, sync, adv, exp_sel, exp_err}
    localparam int NV = 37;
    localparam logic [21:0] VEC [NV] = '{
        {4'd8, 1'b1, 9'h080, 2'd2, 1'b0, 1'b1, 3'b010, 1'b0}, // R3 step, stage
        {4'd3, 1'b0, 9'h000, 2'd2, 1'b0, 1'b1, 3'b001, 1'b0}, // R3
        {4'd3, 1'b0, 9'h000, 2'd2, 1'b0, 1'b1, 3'b100, 1'b0}, // R3 wrap
        {4'd8, 1'b1, 9'h000, 2'd2, 1'b0, 1'b1, 3'b010, 1'b0}, // R8 still forward
        {4'd5, 1'b0, 9'h000, 2'd2, 1'b1, 1'b0, 3'b001, 1'b0}, // R5 reverse starts blue
        {4'd4, 1'b0, 9'h000, 2'd2, 1'b0, 1'b1, 3'b010, 1'b0}, // R4
        {4'd4, 1'b0, 9'h000, 2'd2, 1'b0, 1'b1, 3'b100, 1'b0}, // R4
        {4'd4, 1'b0, 9'h000, 2'd2, 1'b0, 1'b1, 3'b001, 1'b0}, // R4 wrap
        {4'd5, 1'b0, 9'h000, 2'd2, 1'b1, 1'b1, 3'b001, 1'b0}, // R5 priority
        {4'd10,1'b1, 9'h0D0, 2'd1, 1'b0, 1'b0, 3'b001, 1'b0}, // R10 pair ok
        {4'd6, 1'b0, 9'h000, 2'd1, 1'b1, 1'b0, 3'b100, 1'b0}, // R6 first red
        {4'd6, 1'b0, 9'h000, 2'd1, 1'b0, 1'b1, 3'b001, 1'b0}, // R6 skip green
        {4'd6, 1'b0, 9'h000, 2'd1, 1'b0, 1'b1, 3'b100, 1'b0}, // R6
        {4'd6, 1'b1, 9'h050, 2'd1, 1'b0, 1'b0, 3'b100, 1'b0}, // R6 stage reverse
        {4'd6, 1'b0, 9'h000, 2'd1, 1'b1, 1'b0, 3'b001, 1'b0}, // R6 first blue
        {4'd6, 1'b0, 9'h000, 2'd1, 1'b0, 1'b1, 3'b100, 1'b0}, // R6
        {4'd6, 1'b1, 9'h0B0, 2'd1, 1'b0, 1'b0, 3'b100, 1'b0}, // R6 stage g/b
        {4'd6, 1'b0, 9'h000, 2'd1, 1'b1, 1'b0, 3'b010, 1'b0}, // R6 first green
        {4'd6, 1'b0, 9'h000, 2'd1, 1'b0, 1'b1, 3'b001, 1'b0}, // R6
        {4'd6, 1'b0, 9'h000, 2'd1, 1'b0, 1'b1, 3'b010, 1'b0}, // R6 skip red
        {4'd7, 1'b1, 9'h010, 2'd0, 1'b0, 1'b1, 3'b010, 1'b0}, // R7 adv ignored
        {4'd7, 1'b0, 9'h000, 2'd0, 1'b1, 1'b0, 3'b001, 1'b0}, // R7 load blue
        {4'd7, 1'b0, 9'h000, 2'd0, 1'b0, 1'b1, 3'b001, 1'b0}, // R7
        {4'd7, 1'b0, 9'h000, 2'd0, 1'b0, 1'b1, 3'b001, 1'b0}, // R7
        {4'd10,1'b1, 9'h0D0, 2'd0, 1'b0, 1'b0, 3'b001, 1'b1}, // R10 two in one-mode
        {4'd11,1'b0, 9'h000, 2'd0, 1'b1, 1'b0, 3'b001, 1'b1}, // R11 sync ignored
        {4'd11,1'b0, 9'h000, 2'd2, 1'b0, 1'b1, 3'b001, 1'b0}, // R11 held, err clears
        {4'd4, 1'b0, 9'h000, 2'd2, 1'b0, 1'b1, 3'b010, 1'b0}, // R4 old word rules
        {4'd9, 1'b1, 9'h181, 2'd2, 1'b0, 1'b0, 3'b010, 1'b1}, // R9 reserved
        {4'd11,1'b0, 9'h000, 2'd2, 1'b0, 1'b1, 3'b010, 1'b1}, // R11 adv ignored
        {4'd11,1'b0, 9'h000, 2'd2, 1'b1, 1'b0, 3'b010, 1'b1}, // R11 sync ignored
        {4'd9, 1'b1, 9'h080, 2'd2, 1'b0, 1'b1, 3'b010, 1'b0}, // R9 clears
        {4'd8, 1'b0, 9'h000, 2'd2, 1'b0, 1'b1, 3'b100, 1'b0}, // R8 reverse kept
        {4'd4, 1'b0, 9'h000, 2'd2, 1'b0, 1'b1, 3'b001, 1'b0}, // R4
        {4'd5, 1'b0, 9'h000, 2'd2, 1'b1, 1'b0, 3'b100, 1'b0}, // R5 forward red
        {4'd10,1'b0, 9'h000, 2'd1, 1'b0, 1'b0, 3'b100, 1'b1}, // R10 none in pair mode
        {4'd11,1'b0, 9'h000, 2'd1, 1'b0, 1'b1, 3'b100, 1'b1}  // R11
    };

    task automatic check(input string tag, input logic [2:0] exp_sel, input logic exp_err);
        n_chk++;
        if (sel !== exp_sel || cfg_err !== exp_err) begin
            n_fail++;
            $display("FAIL %s: sel=%b err=%b expected sel=%b err=%b",
                     tag, sel, cfg_err, exp_sel, exp_err);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        rst_n     = 1'b0;
        cfg_we    = 1'b0;
        cfg_wdata = '0;
        mode      = 2'd2;
        line_sync = 1'b0;
        adv       = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset", 3'b100, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            {cfg_we, cfg_wdata, mode, line_sync, adv} = VEC[i][17:4];
            @(negedge clk);
            check($sformatf("vec %0d R%0d", i, VEC[i][21:18]), VEC[i][3:1], VEC[i][0]);
        end

        // R1: asynchronous reset mid-run restores red and clears the flag
        cfg_we = 1'b0; line_sync = 1'b0; adv = 1'b0; mode = 2'd2;
        #3 rst_n = 1'b0;
        #2 check("R1 async reset", 3'b100, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R3: the reset word runs forward in three-channel mode
        adv = 1'b1;
        @(negedge clk);
        check("R3 after reset", 3'b010, 1'b0);
        // R2: select stays one-hot across a long advance run
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            check("R2 onehot", (k % 3 == 0) ? 3'b001 : (k % 3 == 1) ? 3'b100 : 3'b010, 1'b0);
        end
        adv = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule